// File: doc/BRIEF.md
# Load-use hazard stall controller

This block sits in the decode stage of a five-stage in-order pipeline. It owns the control fields of the decode/execute pipeline register and watches for the one data dependence that forwarding cannot cover. That dependence arises when the instruction now in execute is a load and the instruction being decoded reads the load's destination register. The loaded value only exists at the end of the load's memory cycle. The dependent instruction, however, needs it at the start of that same cycle.

When the dependence is seen, the controller holds the program counter and the fetch/decode register for one cycle, so the same instructions are fetched and decoded again. In the same cycle it writes all-zero execute, memory and writeback control fields into the decode/execute register. The slot that moves on is a bubble that writes neither memory nor registers. One cycle later the load has reached the memory stage, the condition no longer holds, and the forwarding path from the memory/writeback register delivers the loaded value. Every load-use pair therefore costs exactly one cycle instead of the two a design without forwarding would lose.

The stall decision is combinational from the state already held in the decode/execute register and the source fields of the instruction in decode. The PC and fetch/decode write enables are meant to gate those registers directly in the same cycle.

Top module: `lu_stall_ctrl`

## Requirements
- R1: The stall is raised in the same cycle (combinationally) when the captured memory control has its read bit set (bit 0 of the memory control field) and the captured destination register is non-zero and equal to the decode-stage first source field.
- R2: The stall is raised under the same conditions when the captured destination equals the decode-stage second source field.
- R3: A captured load whose destination register is 0 never raises the stall, even when a source field is also 0.
- R4: With bit 0 of the captured memory control clear, no stall is raised whatever the register numbers are. This includes a store, which has only bit 1 of the memory control set.
- R5: `pc_wr_en` and `fd_wr_en` are both 0 in a stall cycle and both 1 otherwise, and `bubble_sel` is 1 exactly in a stall cycle.
- R6: At the clock edge that ends a stall cycle, the captured execute, memory and writeback control fields all become zero.
- R7: At the clock edge that ends a non-stall cycle, the decoded execute, memory and writeback control fields are captured unchanged. The decoded destination register number is captured at every edge, stall or not.
- R8: When the decode inputs are held after a stall, the stall lasts exactly one cycle, and the held instruction is captured on the following edge.
- R9: A synchronous active-low reset clears all captured control fields and the captured destination, so no stall is raised after reset even when a source field matches the destination that was captured before reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fd_src_a | input | REG_AW (5) | First source register field of the instruction in decode |
| fd_src_b | input | REG_AW (5) | Second source register field of the instruction in decode |
| dec_ex_ctl | input | EX_W (4) | Execute-stage control produced by the decoder |
| dec_mem_ctl | input | MEM_W (2) | Memory-stage control from the decoder; bit 0 = memory read, bit 1 = memory write |
| dec_wb_ctl | input | WB_W (2) | Writeback-stage control produced by the decoder |
| dec_dst | input | REG_AW (5) | Register number a load in decode would write |
| pc_wr_en | output | 1 | Program counter write enable; 0 holds the PC |
| fd_wr_en | output | 1 | Fetch/decode register write enable; 0 holds it |
| bubble_sel | output | 1 | 1 when all-zero control is being written into decode/execute |
| de_ex_ctl | output | EX_W (4) | Captured execute control |
| de_mem_ctl | output | MEM_W (2) | Captured memory control |
| de_wb_ctl | output | WB_W (2) | Captured writeback control |
| de_dst | output | REG_AW (5) | Captured destination register number |

## Verification
The bench goes after a load followed directly by a user of its result through either source field. A controller that compared only one field would let the instruction run with the stale value. It also places a load to register 0 ahead of a reader of register 0, and a store or ALU instruction ahead of a reader of its register. A design that ignored the zero register or the read bit would stall needlessly in those cases and lose a cycle. After every stall it checks that the bubble carries all-zero control and that the stall drops on the next cycle. A design that forgot to zero the memory read bit would stall forever. A final reset taken while a hazardous load is captured must clear the pending stall.

// File: rtl/lu_stall_pkg.sv
// Package: lu_stall_pkg
// Shared widths and field positions for the load-use stall controller.
// Assumes the memory-stage control field carries the read request in a
// fixed bit; the comparator and the checker both decode that bit.
package lu_stall_pkg;

    localparam int unsigned LU_REG_AW   = 5;   // register number width
    localparam int unsigned LU_EX_W     = 4;   // execute control width
    localparam int unsigned LU_MEM_W    = 2;   // memory control width
    localparam int unsigned LU_WB_W     = 2;   // writeback control width
    localparam int unsigned LU_MEMRD_BIT = 0;  // read-request bit in memory control
    localparam int unsigned LU_NSRC     = 2;   // source fields compared per instruction

endpackage

// File: rtl/lu_src_match.sv
// Module: lu_src_match
// Compares the destination of the instruction held in decode/execute
// against every source field of the instruction in decode. Reports a
// hit only when the held instruction is a load and its destination is a
// writable register. Assumes register 0 is hard-wired to zero when
// ZERO_REG_FIXED is set.
module lu_src_match #(
    parameter int unsigned REG_AW         = 5,
    parameter int unsigned NSRC           = 2,
    parameter bit          ZERO_REG_FIXED = 1'b1
) (
    input  logic                        is_load,
    input  logic [REG_AW-1:0]           dst,
    input  logic [NSRC-1:0][REG_AW-1:0] srcs,
    output logic                        hit
);

    logic [NSRC-1:0] per_src;
    logic            dst_ok;

    // One equality comparator per source field.
    for (genvar s = 0; s < NSRC; s++) begin : g_cmp
        assign per_src[s] = (srcs[s] == dst);
    end

    // Pick whether a write to register 0 can ever be a real dependence.
    if (ZERO_REG_FIXED) begin : g_zero_fixed
        assign dst_ok = (dst != '0);
    end else begin : g_zero_plain
        assign dst_ok = 1'b1;
    end

    // Combine load flag, destination validity and any source hit.
    always_comb begin
        hit = is_load && dst_ok && (|per_src);
    end

endmodule

// File: rtl/lu_bubble_mux.sv
// Module: lu_bubble_mux
// Replaces a control field with all zeros when a bubble is selected.
// Assumes a zero control word means "no architectural side effect".
module lu_bubble_mux #(
    parameter int unsigned W = 4
) (
    input  logic         kill,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    // Zero the field on a bubble, pass it through otherwise.
    always_comb begin
        dout = kill ? '0 : din;
    end

endmodule

// File: rtl/lu_de_ctl_reg.sv
// Module: lu_de_ctl_reg
// Control and destination part of the decode/execute pipeline register.
// Updates every cycle; assumes the pipeline behind decode never stalls
// on its own (stalls from later stages are out of scope).
module lu_de_ctl_reg #(
    parameter int unsigned REG_AW = 5,
    parameter int unsigned EX_W   = 4,
    parameter int unsigned MEM_W  = 2,
    parameter int unsigned WB_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [EX_W-1:0]   ex_d,
    input  logic [MEM_W-1:0]  mem_d,
    input  logic [WB_W-1:0]   wb_d,
    input  logic [REG_AW-1:0] dst_d,
    output logic [EX_W-1:0]   ex_q,
    output logic [MEM_W-1:0]  mem_q,
    output logic [WB_W-1:0]   wb_q,
    output logic [REG_AW-1:0] dst_q
);

    // Capture the next slot, clearing it on synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ex_q  <= '0;
            mem_q <= '0;
            wb_q  <= '0;
            dst_q <= '0;
        end else begin
            ex_q  <= ex_d;
            mem_q <= mem_d;
            wb_q  <= wb_d;
            dst_q <= dst_d;
        end
    end

endmodule

// File: rtl/lu_stall_ctrl.sv
// Module: lu_stall_ctrl (top)
// Load-use hazard detection for the decode stage. Holds the control
// fields of decode/execute, raises a one-cycle stall when the held
// instruction is a load feeding the instruction in decode, freezes the
// PC and fetch/decode register, and inserts a zero-control bubble.
// Assumes forwarding from memory/writeback covers the cycle after.
module lu_stall_ctrl
    import lu_stall_pkg::*;
#(
    parameter int unsigned REG_AW    = LU_REG_AW,
    parameter int unsigned EX_W      = LU_EX_W,
    parameter int unsigned MEM_W     = LU_MEM_W,
    parameter int unsigned WB_W      = LU_WB_W,
    parameter int unsigned MEMRD_BIT = LU_MEMRD_BIT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] fd_src_a,
    input  logic [REG_AW-1:0] fd_src_b,
    input  logic [EX_W-1:0]   dec_ex_ctl,
    input  logic [MEM_W-1:0]  dec_mem_ctl,
    input  logic [WB_W-1:0]   dec_wb_ctl,
    input  logic [REG_AW-1:0] dec_dst,
    output logic              pc_wr_en,
    output logic              fd_wr_en,
    output logic              bubble_sel,
    output logic [EX_W-1:0]   de_ex_ctl,
    output logic [MEM_W-1:0]  de_mem_ctl,
    output logic [WB_W-1:0]   de_wb_ctl,
    output logic [REG_AW-1:0] de_dst
);

    localparam int unsigned NSRC = LU_NSRC;

    logic [NSRC-1:0][REG_AW-1:0] srcs;
    logic                        hazard;
    logic [EX_W-1:0]             ex_next;
    logic [MEM_W-1:0]            mem_next;
    logic [WB_W-1:0]             wb_next;

    // Gather the decode-stage source fields for the comparator array.
    always_comb begin
        srcs[0] = fd_src_a;
        srcs[1] = fd_src_b;
    end

    lu_src_match #(
        .REG_AW         (REG_AW),
        .NSRC           (NSRC),
        .ZERO_REG_FIXED (1'b1)
    ) u_match (
        .is_load (de_mem_ctl[MEMRD_BIT]),
        .dst     (de_dst),
        .srcs    (srcs),
        .hit     (hazard)
    );

    lu_bubble_mux #(.W(EX_W)) u_kill_ex (
        .kill (hazard), .din (dec_ex_ctl), .dout (ex_next)
    );

    lu_bubble_mux #(.W(MEM_W)) u_kill_mem (
        .kill (hazard), .din (dec_mem_ctl), .dout (mem_next)
    );

    lu_bubble_mux #(.W(WB_W)) u_kill_wb (
        .kill (hazard), .din (dec_wb_ctl), .dout (wb_next)
    );

    lu_de_ctl_reg #(
        .REG_AW (REG_AW),
        .EX_W   (EX_W),
        .MEM_W  (MEM_W),
        .WB_W   (WB_W)
    ) u_de_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .ex_d  (ex_next),
        .mem_d (mem_next),
        .wb_d  (wb_next),
        .dst_d (dec_dst),
        .ex_q  (de_ex_ctl),
        .mem_q (de_mem_ctl),
        .wb_q  (de_wb_ctl),
        .dst_q (de_dst)
    );

    // Drive the front-end hold enables and the bubble select.
    always_comb begin
        pc_wr_en   = !hazard;
        fd_wr_en   = !hazard;
        bubble_sel = hazard;
    end

endmodule

// File: rtl/lu_stall_ctrl_chk.sv
// Module: lu_stall_ctrl_chk
// Property checker for lu_stall_ctrl, attached by bind below.
module lu_stall_ctrl_chk #(
    parameter int unsigned REG_AW    = 5,
    parameter int unsigned EX_W      = 4,
    parameter int unsigned MEM_W     = 2,
    parameter int unsigned WB_W      = 2,
    parameter int unsigned MEMRD_BIT = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic [REG_AW-1:0] fd_src_a,
    input logic [REG_AW-1:0] fd_src_b,
    input logic [EX_W-1:0]   dec_ex_ctl,
    input logic [MEM_W-1:0]  dec_mem_ctl,
    input logic [WB_W-1:0]   dec_wb_ctl,
    input logic              pc_wr_en,
    input logic              fd_wr_en,
    input logic              bubble_sel,
    input logic [EX_W-1:0]   de_ex_ctl,
    input logic [MEM_W-1:0]  de_mem_ctl,
    input logic [WB_W-1:0]   de_wb_ctl,
    input logic [REG_AW-1:0] de_dst
);

    // R1: load feeding the first source field stalls.
    assert_src_a_stall_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (de_mem_ctl[MEMRD_BIT] && de_dst != '0 && de_dst == fd_src_a) |-> bubble_sel);

    // R2: load feeding the second source field stalls.
    assert_src_b_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (de_mem_ctl[MEMRD_BIT] && de_dst != '0 && de_dst == fd_src_b) |-> bubble_sel);

    // R3: a load into register 0 never stalls.
    assert_zero_dst_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (de_dst == '0) |-> !bubble_sel);

    // R4: no read request held, no stall.
    assert_no_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !de_mem_ctl[MEMRD_BIT] |-> !bubble_sel);

    // R5: hold enables agree with each other and oppose the bubble select.
    assert_enables_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_wr_en == fd_wr_en) && (pc_wr_en != bubble_sel));

    // R6: a stall cycle leaves zeroed control behind it.
    assert_bubble_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bubble_sel |=> (de_ex_ctl == '0 && de_mem_ctl == '0 && de_wb_ctl == '0));

    // R7: a non-stall cycle captures decoded control unchanged.
    assert_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !bubble_sel |=> (de_ex_ctl == $past(dec_ex_ctl) && de_mem_ctl == $past(dec_mem_ctl)
                         && de_wb_ctl == $past(dec_wb_ctl)));

    // R8: a stall never lasts two cycles in a row.
    assert_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bubble_sel |=> !bubble_sel);

endmodule

bind lu_stall_ctrl lu_stall_ctrl_chk #(
    .REG_AW    (REG_AW),
    .EX_W      (EX_W),
    .MEM_W     (MEM_W),
    .WB_W      (WB_W),
    .MEMRD_BIT (MEMRD_BIT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fd_src_a    (fd_src_a),
    .fd_src_b    (fd_src_b),
    .dec_ex_ctl  (dec_ex_ctl),
    .dec_mem_ctl (dec_mem_ctl),
    .dec_wb_ctl  (dec_wb_ctl),
    .pc_wr_en    (pc_wr_en),
    .fd_wr_en    (fd_wr_en),
    .bubble_sel  (bubble_sel),
    .de_ex_ctl   (de_ex_ctl),
    .de_mem_ctl  (de_mem_ctl),
    .de_wb_ctl   (de_wb_ctl),
    .de_dst      (de_dst)
);

// File: tb/lu_stall_ctrl_bench.sv
// Bench for lu_stall_ctrl: a vector table walked in order, then directed
// reset and corner tests. Memory control: bit 0 = read, bit 1 = write.
module lu_stall_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] fd_src_a = '0;
    logic [4:0] fd_src_b = '0;
    logic [3:0] dec_ex_ctl = '0;
    logic [1:0] dec_mem_ctl = '0;
    logic [1:0] dec_wb_ctl = '0;
    logic [4:0] dec_dst = '0;
    logic       pc_wr_en, fd_wr_en, bubble_sel;
    logic [3:0] de_ex_ctl;
    logic [1:0] de_mem_ctl;
    logic [1:0] de_wb_ctl;
    logic [4:0] de_dst;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    lu_stall_ctrl u_lu_stall_ctrl (
        .clk, .rst_n, .fd_src_a, .fd_src_b, .dec_ex_ctl, .dec_mem_ctl,
        .dec_wb_ctl, .dec_dst, .pc_wr_en, .fd_wr_en, .bubble_sel,
        .de_ex_ctl, .de_mem_ctl, .de_wb_ctl, .de_dst
    );

    // Vector: {ex[23:20], mem[19:18], wb[17:16], dst[15:11], srcA[10:6], srcB[5:1], stall[0]}
    localparam int NV = 14;
    localparam logic [23:0] VEC [NV] = '{
        {4'h3, 2'b01, 2'b11, 5'd2,  5'd1,  5'd3,  1'b0}, // load r2, nothing held
        {4'h9, 2'b00, 2'b10, 5'd12, 5'd2,  5'd5,  1'b1}, // reads r2 via A: stall
        {4'h9, 2'b00, 2'b10, 5'd12, 5'd2,  5'd5,  1'b0}, // held, bubble in front
        {4'h3, 2'b01, 2'b11, 5'd7,  5'd12, 5'd4,  1'b0}, // ALU r12 ahead: no stall
        {4'h5, 2'b00, 2'b10, 5'd13, 5'd6,  5'd7,  1'b1}, // reads r7 via B: stall
        {4'h5, 2'b00, 2'b10, 5'd13, 5'd6,  5'd7,  1'b0}, // held
        {4'h3, 2'b01, 2'b11, 5'd0,  5'd13, 5'd0,  1'b0}, // load into r0
        {4'h6, 2'b00, 2'b10, 5'd8,  5'd0,  5'd0,  1'b0}, // reads r0: no stall
        {4'h3, 2'b01, 2'b11, 5'd9,  5'd8,  5'd8,  1'b0}, // load r9
        {4'h1, 2'b10, 2'b00, 5'd9,  5'd9,  5'd9,  1'b1}, // store reads r9 twice: stall
        {4'h1, 2'b10, 2'b00, 5'd9,  5'd9,  5'd9,  1'b0}, // held
        {4'h9, 2'b00, 2'b10, 5'd3,  5'd9,  5'd9,  1'b0}, // store r9 ahead: no stall
        {4'h3, 2'b01, 2'b11, 5'd5,  5'd1,  5'd2,  1'b0}, // load r5
        {4'h9, 2'b00, 2'b10, 5'd10, 5'd4,  5'd6,  1'b0}  // unrelated sources
    };

    // Compare one value and report a mismatch.
    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Drive one decode slot, check the comb outputs, clock it, check capture.
    task automatic step(input logic [23:0] v, input string tag);
        logic st;
        st = v[0];
        @(negedge clk);
        dec_ex_ctl  = v[23:20];
        dec_mem_ctl = v[19:18];
        dec_wb_ctl  = v[17:16];
        dec_dst     = v[15:11];
        fd_src_a    = v[10:6];
        fd_src_b    = v[5:1];
        #2;
        chk({tag, " R1/R2/R3/R4 stall"}, 32'(bubble_sel), 32'(st));
        chk({tag, " R5 pc_wr_en"}, 32'(pc_wr_en), 32'(!st));
        chk({tag, " R5 fd_wr_en"}, 32'(fd_wr_en), 32'(!st));
        @(posedge clk);
        #1;
        if (st) begin
            chk({tag, " R6 bubble control"}, {24'd0, de_ex_ctl, de_mem_ctl, de_wb_ctl}, 32'd0);
        end else begin
            chk({tag, " R7 captured control"}, {24'd0, de_ex_ctl, de_mem_ctl, de_wb_ctl},
                {24'd0, v[23:16]});
        end
        chk({tag, " R7 captured dst"}, 32'(de_dst), 32'(v[15:11]));
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000 && !done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d cycles expected<=5000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R9: reset state
        chk("R9 reset control", {24'd0, de_ex_ctl, de_mem_ctl, de_wb_ctl}, 32'd0);
        chk("R9 reset dst", 32'(de_dst), 32'd0);
        chk("R9 reset no stall", 32'(bubble_sel), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(VEC[i], $sformatf("vec%0d", i));
        end

        // R8: held decode after a stall drops the stall after one cycle.
        step({4'h3, 2'b01, 2'b11, 5'd11, 5'd0,  5'd0,  1'b0}, "r8 load r11");
        step({4'hA, 2'b00, 2'b01, 5'd14, 5'd11, 5'd11, 1'b1}, "r8 stall");
        step({4'hA, 2'b00, 2'b01, 5'd14, 5'd11, 5'd11, 1'b0}, "r8 release");

        // R9: reset while a hazardous load is held clears the pending stall.
        step({4'h3, 2'b01, 2'b11, 5'd4,  5'd0,  5'd0,  1'b0}, "r9 load r4");
        @(negedge clk);
        fd_src_a = 5'd4;
        fd_src_b = 5'd0;
        dec_ex_ctl = 4'hF;
        dec_mem_ctl = 2'b01;
        dec_wb_ctl = 2'b11;
        dec_dst = 5'd4;
        #2;
        chk("R1 stall before reset", 32'(bubble_sel), 32'd1);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        chk("R9 reset clears control", {24'd0, de_ex_ctl, de_mem_ctl, de_wb_ctl}, 32'd0);
        chk("R9 reset clears dst", 32'(de_dst), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        chk("R9 no stall after reset", 32'(bubble_sel), 32'd0);
        chk("R9 pc_wr_en after reset", 32'(pc_wr_en), 32'd1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule